// File: doc/BRIEF.md
# Binary32 / Signed Integer Converter

This unit converts numbers in both directions between IEEE-754 single-precision values and signed two's-complement integers of 32 or 64 bits. One operation selector picks the direction and the integer width. A one-bit rounding selector picks either round-to-nearest-even or round-toward-zero. The result comes out of a single register stage with a valid strobe. Integer results always fill the full 64-bit output. Float results fill a 32-bit output.

When a float is converted to an integer, values that cannot be represented are clamped to the nearest integer limit and raise the invalid flag. NaN is clamped to the largest positive integer. When an integer is converted to a float, the only flag that can be raised is inexact. An integer operand of zero always gives positive zero.

Top module: `cvt_unit`

## Requirements
- R1: `out_valid` is high exactly one clock cycle after a cycle in which `in_valid` was high, and low otherwise. While `rst` is high, every output reads zero.
- R2: `op` encodings are: 0 = float to 32-bit integer, 1 = float to 64-bit integer, 2 = 32-bit integer to float, 3 = 64-bit integer to float. `rm` encodings are: 0 = round to nearest with ties to even, 1 = round toward zero.
- R3: A float-to-integer conversion whose rounded value fits the target width returns that value. A 32-bit result is sign-extended to 64 bits on `int_out`.
- R4: A NaN input to a float-to-integer conversion returns the largest positive integer of the target width, with `flag_invalid` set.
- R5: An infinity or a finite value whose rounded magnitude is outside the target range saturates. Positive values go to the most positive integer and negative values to the most negative integer. `flag_invalid` is set and `flag_inexact` is clear.
- R6: For an in-range float-to-integer conversion, `flag_inexact` is set exactly when the input has a nonzero fractional part. `flag_invalid` is clear.
- R7: Integer-to-float conversion rounds according to `rm`. Mode 2 uses only bits 31:0 of `int_in` as a signed value and ignores bits 63:32. Mode 3 uses all 64 bits. `flag_inexact` is set when the value is not exactly representable.
- R8: An integer operand equal to zero converts to +0.0 (0x00000000) with both flags clear.
- R9: For float-to-integer modes `fp_out` is zero. For integer-to-float modes `int_out` is zero and `flag_invalid` is clear.
- R10: In a cycle after `in_valid` was low, `int_out`, `fp_out` and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selectors are valid this cycle |
| op | input | 2 | Direction and integer-width select |
| rm | input | 1 | Rounding-mode select |
| int_in | input | 64 | Integer operand |
| fp_in | input | 32 | Single-precision operand |
| out_valid | output | 1 | Results below are fresh |
| int_out | output | 64 | Integer result |
| fp_out | output | 32 | Single-precision result |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Inexact flag |

## Verification
The properties assume that `op`, `rm` and both operands carry known values in every cycle where `in_valid` is high. They also assume that reset is asserted from time zero, so no property looks at a cycle before reset ends. The stimulus changes inputs only on falling clock edges and holds reset high for several cycles before the first operation. It fills every unused operand with defined values: upper integer bits in 32-bit integer mode, and a fixed float pattern in integer modes. As a result, every property's antecedent sees only defined data.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;
    localparam int XLEN   = 64;
    localparam int W_BITS = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    typedef enum logic [1:0] {
        OP_F2W = 2'd0,
        OP_F2L = 2'd1,
        OP_W2F = 2'd2,
        OP_L2F = 2'd3
    } cvt_op_e;

    typedef enum logic {
        RM_RNE = 1'b0,
        RM_RTZ = 1'b1
    } cvt_rm_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } sp_t;

    typedef struct packed {
        logic [XLEN-1:0] ival;
        logic [FP_W-1:0] fval;
        logic            invalid;
        logic            inexact;
    } cvt_res_t;

    function automatic logic round_inc(cvt_rm_e rm, logic lsb, logic rnd, logic stk);
        return (rm == RM_RNE) && rnd && (stk || lsb);
    endfunction
endpackage

// File: rtl/cvt_lzc.sv
`timescale 1ns/1ps
module cvt_lzc #(
    parameter int W     = 64,
    localparam int CW   = $clog2(W)
) (
    input  logic [W-1:0]  d,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            if (d[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/cvt_f2i.sv
`timescale 1ns/1ps
module cvt_f2i
    import cvt_pkg::*;
(
    input  sp_t             a,
    input  logic            is_long,
    input  cvt_rm_e         rm,
    output logic [XLEN-1:0] result,
    output logic            invalid,
    output logic            inexact
);
    localparam int FRAC_B = MAN_W + 2;
    localparam int WIDE_W = XLEN + FRAC_B;
    localparam int LO_E   = BIAS - 2;
    localparam int HI_E   = BIAS + XLEN - 1;
    localparam logic [EXP_W-1:0] E_MAX = '1;

    logic            is_nan, is_inf, in_win, too_big;
    logic [EXP_W-1:0] sh;
    logic [WIDE_W-1:0] wide;
    logic [XLEN-1:0] mag;
    logic            rnd, stk, up;
    logic [XLEN:0]   mag_r, pos_lim, neg_lim;
    logic            ovf;
    logic [XLEN-1:0] pos_max, neg_max, signed_v;

    assign is_nan  = (a.exp == E_MAX) && (a.man != '0);
    assign is_inf  = (a.exp == E_MAX) && (a.man == '0);
    assign in_win  = (a.exp >= EXP_W'(LO_E)) && (a.exp <= EXP_W'(HI_E));
    assign too_big = (a.exp > EXP_W'(HI_E)) && (a.exp != E_MAX);
    assign sh      = a.exp - EXP_W'(LO_E);
    assign wide    = {{(WIDE_W-MAN_W-1){1'b0}}, 1'b1, a.man} << sh;

    always_comb begin
        if (in_win) begin
            mag = wide[WIDE_W-1:FRAC_B];
            rnd = wide[FRAC_B-1];
            stk = |wide[FRAC_B-2:0];
        end else begin
            mag = '0;
            rnd = 1'b0;
            stk = (a.exp != '0) || (a.man != '0);
        end
    end

    assign up      = round_inc(rm, mag[0], rnd, stk);
    assign mag_r   = {1'b0, mag} + {{XLEN{1'b0}}, up};
    assign pos_lim = is_long ? (({{XLEN{1'b0}}, 1'b1} << (XLEN-1)) - 1'b1)
                             : (({{XLEN{1'b0}}, 1'b1} << (W_BITS-1)) - 1'b1);
    assign neg_lim = pos_lim + 1'b1;
    assign ovf     = too_big || is_inf ||
                     (in_win && (a.sign ? (mag_r > neg_lim) : (mag_r > pos_lim)));

    assign pos_max = is_long ? {1'b0, {(XLEN-1){1'b1}}}
                             : {{(XLEN-W_BITS+1){1'b0}}, {(W_BITS-1){1'b1}}};
    assign neg_max = is_long ? {1'b1, {(XLEN-1){1'b0}}}
                             : {{(XLEN-W_BITS+1){1'b1}}, {(W_BITS-1){1'b0}}};
    assign signed_v = a.sign ? (~mag_r[XLEN-1:0] + 1'b1) : mag_r[XLEN-1:0];

    always_comb begin
        invalid = is_nan || ovf;
        inexact = 1'b0;
        if (is_nan || (ovf && !a.sign)) begin
            result = pos_max;
        end else if (ovf) begin
            result = neg_max;
        end else begin
            inexact = rnd || stk;
            result  = is_long ? signed_v
                              : {{(XLEN-W_BITS){signed_v[W_BITS-1]}}, signed_v[W_BITS-1:0]};
        end
    end
endmodule

// File: rtl/cvt_i2f.sv
`timescale 1ns/1ps
module cvt_i2f
    import cvt_pkg::*;
(
    input  logic [XLEN-1:0] x,
    input  logic            is_long,
    input  cvt_rm_e         rm,
    output sp_t             result,
    output logic            inexact
);
    localparam int CW    = $clog2(XLEN);
    localparam int RND_B = XLEN - 2 - MAN_W;

    logic [XLEN-1:0]  src, mag, norm;
    logic             sign, is_zero, rnd, stk, up, carry;
    logic [CW-1:0]    lz;
    logic [MAN_W-1:0] man;
    logic [MAN_W:0]   man_r;
    logic [EXP_W-1:0] exp_v;

    assign src  = is_long ? x : {{(XLEN-W_BITS){x[W_BITS-1]}}, x[W_BITS-1:0]};
    assign sign = src[XLEN-1];
    assign mag  = sign ? (~src + 1'b1) : src;

    cvt_lzc #(.W(XLEN)) u_lzc (
        .d   (mag),
        .cnt (lz)
    );

    assign norm    = mag << lz;
    assign is_zero = ~norm[XLEN-1];
    assign man     = norm[XLEN-2 -: MAN_W];
    assign rnd     = norm[RND_B];
    assign stk     = |norm[RND_B-1:0];
    assign up      = round_inc(rm, man[0], rnd, stk);
    assign man_r   = {1'b0, man} + {{MAN_W{1'b0}}, up};
    assign carry   = man_r[MAN_W];
    assign exp_v   = EXP_W'(BIAS + XLEN - 1) - EXP_W'(lz) + EXP_W'(carry);

    always_comb begin
        if (is_zero) begin
            result  = '0;
            inexact = 1'b0;
        end else begin
            result.sign = sign;
            result.exp  = exp_v;
            result.man  = man_r[MAN_W-1:0];
            inexact     = rnd || stk;
        end
    end
endmodule

// File: rtl/cvt_unit.sv
`timescale 1ns/1ps
module cvt_unit
    import cvt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic            rm,
    input  logic [63:0]     int_in,
    input  logic [31:0]     fp_in,
    output logic            out_valid,
    output logic [63:0]     int_out,
    output logic [31:0]     fp_out,
    output logic            flag_invalid,
    output logic            flag_inexact
);
    cvt_op_e         op_e;
    cvt_rm_e         rm_e;
    logic [XLEN-1:0] f2i_val;
    logic            f2i_inv, f2i_inx, i2f_inx;
    sp_t             i2f_val;
    cvt_res_t        res_d, res_q;
    logic            vld_q;

    assign op_e = cvt_op_e'(op);
    assign rm_e = cvt_rm_e'(rm);

    cvt_f2i u_f2i (
        .a       (sp_t'(fp_in)),
        .is_long (op_e == OP_F2L),
        .rm      (rm_e),
        .result  (f2i_val),
        .invalid (f2i_inv),
        .inexact (f2i_inx)
    );

    cvt_i2f u_i2f (
        .x       (int_in),
        .is_long (op_e == OP_L2F),
        .rm      (rm_e),
        .result  (i2f_val),
        .inexact (i2f_inx)
    );

    always_comb begin
        res_d = '0;
        if (op_e == OP_W2F || op_e == OP_L2F) begin
            res_d.fval    = i2f_val;
            res_d.inexact = i2f_inx;
        end else begin
            res_d.ival    = f2i_val;
            res_d.invalid = f2i_inv;
            res_d.inexact = f2i_inx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_valid    = vld_q;
    assign int_out      = res_q.ival;
    assign fp_out       = res_q.fval;
    assign flag_invalid = res_q.invalid;
    assign flag_inexact = res_q.inexact;
endmodule

// File: rtl/cvt_unit_chk.sv
`timescale 1ns/1ps
module cvt_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  op,
    input logic [63:0] int_in,
    input logic [31:0] fp_in,
    input logic        out_valid,
    input logic [63:0] int_out,
    input logic [31:0] fp_out,
    input logic        flag_invalid,
    input logic        flag_inexact
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_word_sign_ext_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd0) |=> (int_out[63:32] == {32{int_out[31]}}));
    assert_nan_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd1 && fp_in[30:23] == 8'hFF && fp_in[22:0] != '0)
        |=> (int_out == 64'h7FFF_FFFF_FFFF_FFFF && flag_invalid));
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> !flag_inexact);
    assert_zero_int_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd3 && int_in == '0) |=> (fp_out == '0 && !flag_inexact));
    assert_i2f_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[1]) |=> (int_out == '0 && !flag_invalid));
    assert_f2i_fp_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op[1]) |=> (fp_out == '0));
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(int_out) && $stable(fp_out) &&
                       $stable(flag_invalid) && $stable(flag_inexact)));
endmodule

bind cvt_unit cvt_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .op           (op),
    .int_in       (int_in),
    .fp_in        (fp_in),
    .out_valid    (out_valid),
    .int_out      (int_out),
    .fp_out       (fp_out),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
);

// File: tb/sim_cvt_unit.sv
`timescale 1ns/1ps
module sim_cvt_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        rm = 1'b0;
    logic [63:0] int_in = '0;
    logic [31:0] fp_in = '0;
    logic        out_valid;
    logic [63:0] int_out;
    logic [31:0] fp_out;
    logic        flag_invalid;
    logic        flag_inexact;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cvt_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rm(rm),
        .int_in(int_in), .fp_in(fp_in), .out_valid(out_valid),
        .int_out(int_out), .fp_out(fp_out),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model_f2i(input logic [31:0] x, input bit is_long, input bit rtz,
                                      output logic [63:0] res, output bit inv, output bit inx);
        logic [63:0] pmax, nmax;
        real lim, r, t, fr;
        bit  sg, ovf;
        int  e;
        longint m;
        pmax = is_long ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        nmax = is_long ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
        lim  = is_long ? 2.0 ** 63 : 2.0 ** 31;
        sg   = x[31];
        e    = int'(x[30:23]);
        if (e == 255) begin
            inv = 1; inx = 0;
            res = (x[22:0] != 0 || !sg) ? pmax : nmax;
            return;
        end
        if (e == 0) r = real'(x[22:0]) * 2.0 ** (-149);
        else        r = (8388608.0 + real'(x[22:0])) * 2.0 ** (e - 150);
        t  = $floor(r);
        fr = r - t;
        if (!rtz && (fr > 0.5 || (fr == 0.5 && (longint'(t) % 2) != 0))) t = t + 1.0;
        ovf = sg ? (t > lim) : (t >= lim);
        if (ovf) begin
            inv = 1; inx = 0;
            res = sg ? nmax : pmax;
        end else begin
            inv = 0;
            inx = (fr != 0.0);
            if (sg && t == lim) res = nmax;
            else begin
                m   = longint'(t);
                res = sg ? -m : m;
            end
        end
    endfunction

    function automatic void model_i2f(input longint v, input bit rtz,
                                      output logic [31:0] res, output bit inx);
        logic [63:0] mag, q, rem, half;
        int  p, drop, ex;
        bit  ng, up;
        ng  = (v < 0);
        mag = ng ? -v : v;
        res = '0; inx = 0;
        if (mag == 0) return;
        p = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) p = i;
        if (p <= 23) begin
            q = mag << (23 - p);
            rem = 0;
        end else begin
            drop = p - 23;
            q    = mag >> drop;
            rem  = mag & ((64'd1 << drop) - 1);
            half = 64'd1 << (drop - 1);
            up   = !rtz && (rem > half || (rem == half && q[0]));
            q    = q + 64'(up);
        end
        ex = 127 + p;
        if (q[24]) begin
            q  = q >> 1;
            ex = ex + 1;
        end
        res = {ng, ex[7:0], q[22:0]};
        inx = (rem != 0);
    endfunction

    task automatic apply(input logic [1:0] o, input logic r,
                         input logic [63:0] iv, input logic [31:0] fv);
        op = o; rm = r; int_in = iv; fp_in = fv; in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [22:0] fracs [7];
        logic [63:0] er, hold_i;
        logic [31:0] ef, hold_f;
        bit einv, einx;
        string rq;
        fracs = '{23'h000000, 23'h000001, 23'h400000, 23'h7FFFFF,
                  23'h200001, 23'h555555, 23'h200000};

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        check("R1", "int_out in reset", int_out, 64'd0);
        check("R1", "fp_out in reset", 64'(fp_out), 64'd0);
        check("R1", "flags in reset", 64'({flag_invalid, flag_inexact}), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // float to integer sweep (R2 op 0/1, R3..R6, R9)
        for (int s = 0; s < 2; s++)
        for (int e = 0; e < 256; e++)
        for (int k = 0; k < 7; k++)
        for (int r = 0; r < 2; r++)
        for (int w = 0; w < 2; w++) begin
            logic [31:0] x;
            x = {1'(s), 8'(e), fracs[k]};
            apply(2'(w), 1'(r), 64'h0123_4567_89AB_CDEF, x);
            model_f2i(x, w == 1, r == 1, er, einv, einx);
            if (e == 255 && fracs[k] != 0) rq = "R4";
            else if (einv) rq = "R5";
            else rq = "R3";
            check("R1", "out_valid after op", 64'(out_valid), 64'd1);
            check(rq, "f2i int_out", int_out, er);
            check(rq, "f2i invalid", 64'(flag_invalid), 64'(einv));
            check("R6", "f2i inexact", 64'(flag_inexact), 64'(einx));
            check("R9", "f2i fp_out zero", 64'(fp_out), 64'd0);
        end

        // integer to float sweep (R2 op 2/3, R7, R9)
        for (int k = 0; k < 64; k++)
        for (int j = 0; j < 4; j++)
        for (int ng = 0; ng < 2; ng++)
        for (int r = 0; r < 2; r++)
        for (int w = 0; w < 2; w++) begin
            logic [63:0] base, v, drv;
            longint sv;
            base = 64'd1 << k;
            case (j)
                0: v = base;
                1: v = base | (base >> 24);
                2: v = base | (base >> 25) | (base >> 40);
                default: v = base - 1;
            endcase
            if (ng == 1) v = -v;
            if (w == 0) begin
                drv = {32'hA5C3_0F96 ^ 32'(k * 7919), v[31:0]};
                sv  = longint'(signed'(v[31:0]));
            end else begin
                drv = v;
                sv  = longint'(v);
            end
            apply(w == 0 ? 2'd2 : 2'd3, 1'(r), drv, 32'h7FC0_0000);
            model_i2f(sv, r == 1, ef, einx);
            check("R7", "i2f fp_out", 64'(fp_out), 64'(ef));
            check("R7", "i2f inexact", 64'(flag_inexact), 64'(einx));
            check("R9", "i2f int_out zero", int_out, 64'd0);
            check("R9", "i2f invalid clear", 64'(flag_invalid), 64'd0);
        end

        // R8: zero operands, including a 32-bit zero under nonzero upper bits
        apply(2'd3, 1'b0, 64'd0, 32'h3F80_0000);
        check("R8", "zero long", 64'({fp_out, flag_inexact, flag_invalid}), 64'd0);
        apply(2'd2, 1'b1, 64'hFFFF_FFFF_0000_0000, 32'h3F80_0000);
        check("R8", "zero word upper ignored", 64'({fp_out, flag_inexact, flag_invalid}), 64'd0);

        // R10: hold while idle, R1 valid drop
        apply(2'd0, 1'b0, 64'd0, 32'hC0A0_0000);
        check("R3", "-5.0 to word", int_out, 64'hFFFF_FFFF_FFFF_FFFB);
        hold_i = int_out;
        hold_f = fp_out;
        in_valid = 1'b0;
        op = 2'd3; int_in = 64'd12345; fp_in = 32'h7F80_0000;
        repeat (3) @(negedge clk);
        check("R1", "out_valid idle", 64'(out_valid), 64'd0);
        check("R10", "int_out held", int_out, hold_i);
        check("R10", "fp_out held", 64'(fp_out), 64'(hold_f));
        check("R10", "flags held", 64'({flag_invalid, flag_inexact}), 64'd0);

        finish_run();
    end
endmodule